// File: doc/BRIEF.md
# Assertion Failure Dispatcher

This block sits beside a processor core and gathers the pass/fail outputs of the hardware assertion checkers placed around it. On a start pulse it samples the whole checker flag vector and walks it one position per cycle, from position 0 upward. A position counter tracks the walk. The first failing position it meets is kept as the error number. When the walk ends, the block reports the result together with a done pulse.

The error number then goes through a priority map that places it in one of four recovery classes: stop the core, reset the hardware, raise a software interrupt, or enter the dedicated exception-handling routine. Low indices belong to the most severe class. Exactly one action strobe, a single cycle wide, fires for a pass that found a failure. A pass with no failure fires none. A sticky register keeps the last error number until it is cleared.

Top module: `afd_dispatch`

## Requirements
- R1: After a synchronous reset, done_o, err_valid_o, err_num_o, err_class_o, act_o, sticky_valid_o and sticky_num_o are all zero.
- R2: flags_i is sampled on the clock edge where start_i is high. done_o is then high for exactly one cycle, in the cycle after the (N_CHK+1)th following edge, and is low in every cycle before that.
- R3: When a pass finds failures, err_valid_o is 1 and err_num_o holds the lowest flag position that was 1. Both hold until the next pass completes.
- R4: err_class_o encodes the class of the reported index: 0 (halt) for index < HALT_LIM (2), 1 (reset) for index < RESET_LIM (5), 2 (interrupt) for index < IRQ_LIM (10), and 3 (exception routine) otherwise.
- R5: act_o is one-hot, with bit k strobing class k (bit0 halt, bit1 reset, bit2 interrupt, bit3 exception). It is non-zero only in the done_o cycle, and only when err_valid_o is 1.
- R6: A pass with all flags 0 still pulses done_o. It sets err_valid_o, err_num_o and err_class_o to 0 and fires no action strobe.
- R7: A start_i pulse during a scan restarts the walk from position 0 with newly sampled flags. The interrupted pass produces no done_o, and R2 timing counts from the new start.
- R8: sticky_valid_o/sticky_num_o take the error number of every pass that finds a failure and keep it across passes without failure. sticky_clr_i clears them, but an error reported on the same edge wins over the clear.
- R9: Changes on flags_i after the sampling edge have no effect on the result of that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin (or restart) a scan pass |
| flags_i | input | N_CHK | Assertion checker fail flags, 1 = failed |
| sticky_clr_i | input | 1 | Clear the sticky error record |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| err_valid_o | output | 1 | Last pass found a failure |
| err_num_o | output | $clog2(N_CHK) | Lowest failing position of the last pass |
| err_class_o | output | 2 | Recovery class of err_num_o |
| act_o | output | 4 | One-hot action strobes: halt, reset, interrupt, exception |
| sticky_valid_o | output | 1 | Sticky record holds an error |
| sticky_num_o | output | $clog2(N_CHK) | Sticky error number |

## Verification
The embedded assertions watch the strobe vector on every cycle: it stays one-hot, it appears only with done and a valid error, and a clean pass stays quiet. They also check that the sticky record changes only on a clear or on a new error. The bench scenarios are needed for the rest: the exact pass latency, the choice of the lowest failing index, the class boundaries, the restart behaviour, immunity to flag changes during a scan, and the collision of a clear with a new error.

// File: rtl/afd_pkg.sv
package afd_pkg;

  typedef enum logic [1:0] {
    CLS_HALT  = 2'd0,
    CLS_RESET = 2'd1,
    CLS_IRQ   = 2'd2,
    CLS_EXC   = 2'd3
  } afd_class_e;

  localparam int NUM_CLASSES = 4;

  function automatic afd_class_e idx_to_class(input int idx, input int halt_lim,
                                              input int reset_lim, input int irq_lim);
    if (idx < halt_lim)       return CLS_HALT;
    else if (idx < reset_lim) return CLS_RESET;
    else if (idx < irq_lim)   return CLS_IRQ;
    else                      return CLS_EXC;
  endfunction

endpackage

// File: rtl/afd_scan.sv
module afd_scan #(
  parameter int N_CHK = 16,
  parameter int IW    = $clog2(N_CHK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N_CHK-1:0] flags,
  output logic             fin,
  output logic             hit,
  output logic [IW-1:0]    hit_idx
);
  localparam logic [IW-1:0] LAST_POS = IW'(N_CHK - 1);

  logic [N_CHK-1:0] shreg;
  logic [IW-1:0]    pos;
  logic             busy;
  logic             found;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      pos     <= '0;
      busy    <= 1'b0;
      found   <= 1'b0;
      hit_idx <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        shreg   <= flags;
        pos     <= '0;
        busy    <= 1'b1;
        found   <= 1'b0;
        hit_idx <= '0;
      end else if (busy) begin
        if (shreg[0] && !found) begin
          found   <= 1'b1;
          hit_idx <= pos;
        end
        shreg <= {1'b0, shreg[N_CHK-1:1]};
        if (pos == LAST_POS) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  assign hit = found;

  // R2
  fin_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> $past(busy));

  // R3
  first_hit_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && found && !start) |=> (found && $stable(hit_idx)));

endmodule

// File: rtl/afd_classify.sv
module afd_classify
  import afd_pkg::*;
#(
  parameter int N_CHK     = 16,
  parameter int IW        = $clog2(N_CHK),
  parameter int HALT_LIM  = 2,
  parameter int RESET_LIM = 5,
  parameter int IRQ_LIM   = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fin,
  input  logic                   hit,
  input  logic [IW-1:0]          hit_idx,
  output logic                   done,
  output logic                   err_valid,
  output logic [IW-1:0]          err_num,
  output logic [1:0]             err_class,
  output logic [NUM_CLASSES-1:0] act
);
  afd_class_e             cls;
  logic [NUM_CLASSES-1:0] cls_oh;

  always_comb cls = idx_to_class(int'(hit_idx), HALT_LIM, RESET_LIM, IRQ_LIM);

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_oh
    assign cls_oh[g] = (cls == afd_class_e'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      err_valid <= 1'b0;
      err_num   <= '0;
      err_class <= '0;
      act       <= '0;
    end else begin
      done <= fin;
      act  <= '0;
      if (fin) begin
        err_valid <= hit;
        err_num   <= hit ? hit_idx : '0;
        err_class <= hit ? cls : 2'd0;
        act       <= hit ? cls_oh : '0;
      end
    end
  end

  // R5
  act_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act));

  // R5
  act_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    (act != '0) |-> (done && err_valid));

  // R6
  quiet_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err_valid) |-> (act == '0 && err_num == '0));

endmodule

// File: rtl/afd_sticky.sv
module afd_sticky #(
  parameter int N_CHK = 16,
  parameter int IW    = $clog2(N_CHK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fin,
  input  logic          hit,
  input  logic [IW-1:0] hit_idx,
  input  logic          clr,
  output logic          svalid,
  output logic [IW-1:0] snum
);
  always_ff @(posedge clk) begin
    if (rst) begin
      svalid <= 1'b0;
      snum   <= '0;
    end else if (fin && hit) begin
      svalid <= 1'b1;
      snum   <= hit_idx;
    end else if (clr) begin
      svalid <= 1'b0;
      snum   <= '0;
    end
  end

  // R8
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !fin) |=> !svalid);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !(fin && hit)) |=> ($stable(snum) && $stable(svalid)));

endmodule

// File: rtl/afd_dispatch.sv
module afd_dispatch
  import afd_pkg::*;
#(
  parameter int N_CHK     = 16,
  parameter int HALT_LIM  = 2,
  parameter int RESET_LIM = 5,
  parameter int IRQ_LIM   = 10,
  localparam int IW       = $clog2(N_CHK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [N_CHK-1:0] flags_i,
  input  logic             sticky_clr_i,
  output logic             done_o,
  output logic             err_valid_o,
  output logic [IW-1:0]    err_num_o,
  output logic [1:0]       err_class_o,
  output logic [3:0]       act_o,
  output logic             sticky_valid_o,
  output logic [IW-1:0]    sticky_num_o
);
  logic          fin;
  logic          hit;
  logic [IW-1:0] hit_idx;

  afd_scan #(.N_CHK(N_CHK), .IW(IW)) u_scan (
    .clk(clk), .rst(rst), .start(start_i), .flags(flags_i),
    .fin(fin), .hit(hit), .hit_idx(hit_idx)
  );

  afd_classify #(
    .N_CHK(N_CHK), .IW(IW), .HALT_LIM(HALT_LIM),
    .RESET_LIM(RESET_LIM), .IRQ_LIM(IRQ_LIM)
  ) u_cls (
    .clk(clk), .rst(rst), .fin(fin), .hit(hit), .hit_idx(hit_idx),
    .done(done_o), .err_valid(err_valid_o), .err_num(err_num_o),
    .err_class(err_class_o), .act(act_o)
  );

  afd_sticky #(.N_CHK(N_CHK), .IW(IW)) u_sticky (
    .clk(clk), .rst(rst), .fin(fin), .hit(hit), .hit_idx(hit_idx),
    .clr(sticky_clr_i), .svalid(sticky_valid_o), .snum(sticky_num_o)
  );

  // R8
  sticky_tracks_error_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_valid_o) |-> (sticky_valid_o && sticky_num_o == err_num_o));

endmodule

// File: tb/afd_dispatch_test.sv
module afd_dispatch_test;
  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [N-1:0]  flags_i = '0;
  logic          sticky_clr_i = 1'b0;
  logic          done_o, err_valid_o, sticky_valid_o;
  logic [IW-1:0] err_num_o, sticky_num_o;
  logic [1:0]    err_class_o;
  logic [3:0]    act_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit exp_sv = 1'b0;
  int exp_sn = 0;

  always #5 clk = ~clk;

  afd_dispatch #(.N_CHK(N)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .flags_i(flags_i),
    .sticky_clr_i(sticky_clr_i), .done_o(done_o), .err_valid_o(err_valid_o),
    .err_num_o(err_num_o), .err_class_o(err_class_o), .act_o(act_o),
    .sticky_valid_o(sticky_valid_o), .sticky_num_o(sticky_num_o)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  function automatic int low_idx(input logic [N-1:0] f);
    for (int i = 0; i < N; i++) if (f[i]) return i;
    return -1;
  endfunction

  function automatic int exp_class(input int idx);
    if (idx < 2) return 0;
    if (idx < 5) return 1;
    if (idx < 10) return 2;
    return 3;
  endfunction

  // One pass: start with f, switch flags to alt afterwards (R9),
  // optionally assert the sticky clear on the result edge (R8).
  task automatic run_pass(input logic [N-1:0] f, input logic [N-1:0] alt, input bit clr_end);
    int idx, early;
    idx = low_idx(f);
    early = 0;
    flags_i = f;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    flags_i = alt;
    for (int k = 0; k < N; k++) begin
      if (k == N - 1 && clr_end) sticky_clr_i = 1'b1;
      @(negedge clk);
      if (done_o) early++;
    end
    chk(early == 0, "R2 done early", early, 0);
    @(negedge clk);
    sticky_clr_i = 1'b0;
    chk(done_o == 1'b1, "R2 done pulse", int'(done_o), 1);
    if (idx >= 0) begin
      chk(err_valid_o == 1'b1, "R3 err_valid", int'(err_valid_o), 1);
      chk(int'(err_num_o) == idx, "R3/R9 err_num", int'(err_num_o), idx);
      chk(int'(err_class_o) == exp_class(idx), "R4 class", int'(err_class_o), exp_class(idx));
      chk(act_o == 4'(1 << exp_class(idx)), "R5 strobe", int'(act_o), 1 << exp_class(idx));
      exp_sv = 1'b1;
      exp_sn = idx;
    end else begin
      chk(err_valid_o == 1'b0, "R6 err_valid", int'(err_valid_o), 0);
      chk(err_num_o == '0 && err_class_o == 2'd0, "R6 num/class", int'(err_num_o), 0);
      chk(act_o == 4'd0, "R6 no strobe", int'(act_o), 0);
      if (clr_end) begin
        exp_sv = 1'b0;
        exp_sn = 0;
      end
    end
    chk(sticky_valid_o == exp_sv, "R8 sticky valid", int'(sticky_valid_o), int'(exp_sv));
    chk(int'(sticky_num_o) == exp_sn, "R8 sticky num", int'(sticky_num_o), exp_sn);
    @(negedge clk);
    chk(done_o == 1'b0 && act_o == 4'd0, "R5 single cycle", int'(act_o), 0);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done_o == 0 && err_valid_o == 0 && err_num_o == 0 && err_class_o == 0 &&
        act_o == 0 && sticky_valid_o == 0 && sticky_num_o == 0,
        "R1 reset state", int'(act_o), 0);

    // R6 clean pass
    run_pass('0, '1, 1'b0);
    // R4 class boundaries: 0,1,2,4,5,9,10,15
    run_pass(16'h0001, '0, 1'b0);
    run_pass(16'h0002, '0, 1'b0);
    run_pass(16'h0004, '0, 1'b0);
    run_pass(16'h0010, '0, 1'b0);
    run_pass(16'h0020, '0, 1'b0);
    run_pass(16'h0200, '0, 1'b0);
    run_pass(16'h0400, '0, 1'b0);
    run_pass(16'h8000, '0, 1'b0);
    // R3 several failures, lowest wins
    run_pass(16'hF0A8, 16'h0001, 1'b0);
    // R8 sticky survives a clean pass, then plain clear
    run_pass('0, '0, 1'b0);
    sticky_clr_i = 1'b1;
    @(negedge clk);
    sticky_clr_i = 1'b0;
    exp_sv = 1'b0;
    exp_sn = 0;
    chk(sticky_valid_o == 0 && sticky_num_o == 0, "R8 clear", int'(sticky_valid_o), 0);
    // R8 clear colliding with new error: error wins
    run_pass(16'h0040, '0, 1'b1);
    // R8 clear colliding with clean pass: clear applies
    run_pass('0, '0, 1'b1);

    // R7 restart mid-scan
    flags_i = 16'h0002;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    run_pass(16'h0300, '0, 1'b0);

    // Random passes (R3, R4, R5, R9)
    for (int t = 0; t < 40; t++) begin
      logic [N-1:0] f, a;
      f = N'($urandom) & N'($urandom) & N'($urandom);
      a = N'($urandom);
      run_pass(f, a, 1'($urandom_range(0, 3) == 0));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule